// File: doc/BRIEF.md
# Model-Driven Tuning Code Sweep Controller

This block tunes an analog circuit by stepping a digital tuning code upward from zero, one code per step. At each code it asks for a fresh set of six sensor readings and waits for them. It then computes a cost estimate from a stored quadratic model. The model is a constant, plus one linear term and one squared term for each sensor. The sweep stops at the first code where the estimate rises. The code then falls back to the previous setting and is held there.

The model coefficients are written through a small write port before a sweep begins. All arithmetic is signed 16-bit fixed point with 8 fractional bits, and every product and sum saturates. A single multiplier is shared over about twenty cycles for each evaluation. The sensor handshake is a request output paired with a valid input. The controller holds the code and waits for as long as the valid input stays low.

Top module: `knob_sweep_opt`

## Requirements
- R1: After reset, knob_o is 0, cost_o is 0, and busy_o, done_o and meas_req_o are all low.
- R2: Coefficients are signed 16-bit values with 8 fractional bits, at these addresses: address 0 holds the constant, address 1+i holds the linear weight of sensor i, and address 7+i holds the squared weight of sensor i (i = 0..5). Sensor i is bits [16*i+15 : 16*i] of sens_data_i.
- R3: The estimate starts at the constant. For i = 0 to 5 in turn, two terms are added. The first is S((lin_i * x_i) >>> 8). The second is S((sq_i * S((x_i * x_i) >>> 8)) >>> 8). S saturates to [-32768, 32767], and every running sum is also saturated.
- R4: A start pulse while idle does four things: it sets knob_o to 0, raises busy_o, clears done_o and raises meas_req_o. The code rises by exactly one after each evaluation that does not end the sweep.
- R5: While meas_req_o is high and sens_valid_i is low, knob_o does not change and the request stays up. The sensors are sampled in the cycle where both signals are high.
- R6: When an estimate is strictly greater than the one at the previous code, the sweep ends. knob_o returns to the previous code, cost_o shows the previous estimate, done_o rises and busy_o falls. done_o and busy_o are never high together.
- R7: An estimate equal to the previous one does not end the sweep.
- R8: If the code reaches its maximum (63 by default) without a rise, that code is held. cost_o then shows the estimate at that code and done_o rises.
- R9: A start pulse while busy_o is high is ignored, and the sweep continues without restarting.
- R10: A coefficient write is accepted only in a cycle where busy_o is low before the clock edge. Writes made during a sweep are dropped.
- R11: After a sweep ends, done_o, knob_o and cost_o hold until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Pulse that begins a sweep |
| meas_req_o | output | 1 | Request for a sensor sample at the current code |
| sens_valid_i | input | 1 | Sensor data valid; completes the request |
| sens_data_i | input | 96 | Six signed 16-bit sensor readings |
| coef_we_i | input | 1 | Coefficient write enable |
| coef_addr_i | input | 4 | Coefficient address |
| coef_wdata_i | input | 16 | Coefficient value |
| knob_o | output | 6 | Tuning code driven to the analog circuit |
| busy_o | output | 1 | Sweep in progress |
| done_o | output | 1 | Sweep finished; code and cost are final |
| cost_o | output | 16 | Estimate at the final code (signed) |

## Verification
Two functions can fall in the same clock cycle.

The first pair is a coefficient write and the start pulse that opens a sweep. The bench drives both in one cycle. Because the block is still idle at that edge, the write must land. The bench judges this by comparing the final cost with a model that uses the new constant.

The second pair is a start pulse or a coefficient write arriving while a measurement request is pending partway through a sweep. Here the bench expects no effect. It checks the final code, the final cost and the exact number of measurement requests.

// File: rtl/knob_sweep_pkg.sv
// Shared widths, state types and saturating fixed-point helpers for the
// tuning code sweep controller. Assumes two's complement signed data.
package knob_sweep_pkg;

    localparam int DATA_W = 16;
    localparam int FRAC_W = 8;

    typedef logic signed [DATA_W-1:0]   word_t;
    typedef logic signed [2*DATA_W-1:0] wide_t;

    typedef enum logic [1:0] {SW_IDLE, SW_REQ, SW_EVAL} sweep_st_t;
    typedef enum logic [2:0] {EV_IDLE, EV_CONST, EV_SQ, EV_LIN, EV_QD} eval_ph_t;

    // Clamp a double-width value into the signed word range.
    function automatic word_t sat_wide(input wide_t v);
        logic [DATA_W:0] top;
        top = v[2*DATA_W-1:DATA_W-1];
        if ((&top) || !(|top)) return word_t'(v[DATA_W-1:0]);
        else if (v[2*DATA_W-1]) return word_t'({1'b1, {(DATA_W-1){1'b0}}});
        else return word_t'({1'b0, {(DATA_W-1){1'b1}}});
    endfunction

    // Saturating signed addition of two words.
    function automatic word_t add_sat(input word_t a, input word_t b);
        logic signed [DATA_W:0] s;
        s = {a[DATA_W-1], a} + {b[DATA_W-1], b};
        if (s[DATA_W] != s[DATA_W-1])
            return s[DATA_W] ? word_t'({1'b1, {(DATA_W-1){1'b0}}})
                             : word_t'({1'b0, {(DATA_W-1){1'b1}}});
        return word_t'(s[DATA_W-1:0]);
    endfunction

    // Fixed-point multiply: full product, arithmetic shift by FRAC_W, saturate.
    function automatic word_t mul_fix(input word_t a, input word_t b);
        wide_t p;
        p = a * b;
        return sat_wide(p >>> FRAC_W);
    endfunction

endpackage

// File: rtl/knob_coef_store.sv
// Small coefficient register file: one synchronous write port and one
// combinational read port. Writes to addresses at or above DEPTH are dropped,
// and reads there return zero. The caller gates the write enable.
module knob_coef_store
    import knob_sweep_pkg::*;
#(
    parameter int DEPTH = 13,
    parameter int CAW   = 4
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           wr_en_i,
    input  logic [CAW-1:0] waddr_i,
    input  word_t          wdata_i,
    input  logic [CAW-1:0] raddr_i,
    output word_t          rdata_o
);

    word_t mem_r [DEPTH];

    // Clear on reset; store an accepted in-range write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_r[i] <= '0;
        end else if (wr_en_i && (int'(waddr_i) < DEPTH)) begin
            mem_r[waddr_i] <= wdata_i;
        end
    end

    // Combinational read with a guard for unused addresses.
    always_comb begin
        rdata_o = (int'(raddr_i) < DEPTH) ? mem_r[raddr_i] : '0;
    end

endmodule

// File: rtl/knob_quad_eval.sv
// Quadratic cost evaluator built around one shared multiplier.
// On go_i it latches the sensor vector. It loads the constant, then for each
// sensor in order it forms the square, adds the linear term and adds the
// squared term. done_o pulses for one cycle with cost_o valid. It assumes
// go_i only arrives while the evaluator is idle, and that coefficients do
// not change during an evaluation.
module knob_quad_eval
    import knob_sweep_pkg::*;
#(
    parameter int NUM_SENS = 6,
    parameter int CAW      = 4,
    localparam int IW      = (NUM_SENS > 1) ? $clog2(NUM_SENS) : 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       go_i,
    input  logic [NUM_SENS*DATA_W-1:0] sens_i,
    output logic [CAW-1:0]             coef_raddr_o,
    input  word_t                      coef_rdata_i,
    output logic                       done_o,
    output word_t                      cost_o
);

    localparam logic [IW-1:0] LAST = IW'(NUM_SENS - 1);

    word_t    xs_r [NUM_SENS];
    word_t    sq_r;
    word_t    acc_r;
    logic [IW-1:0] idx_r;
    eval_ph_t ph_r;
    word_t    mul_a;
    word_t    mul_b;
    word_t    prod;
    word_t    acc_sum;

    // Select the multiplier operands and coefficient address for this phase.
    always_comb begin
        coef_raddr_o = '0;
        mul_a        = xs_r[idx_r];
        mul_b        = xs_r[idx_r];
        case (ph_r)
            EV_LIN: begin
                coef_raddr_o = CAW'(1 + int'(idx_r));
                mul_a        = coef_rdata_i;
            end
            EV_QD: begin
                coef_raddr_o = CAW'(1 + NUM_SENS + int'(idx_r));
                mul_a        = coef_rdata_i;
                mul_b        = sq_r;
            end
            default: ;
        endcase
        prod    = mul_fix(mul_a, mul_b);
        acc_sum = add_sat(acc_r, prod);
    end

    // Step through the evaluation phases and accumulate the estimate.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NUM_SENS; i++) xs_r[i] <= '0;
            sq_r   <= '0;
            acc_r  <= '0;
            idx_r  <= '0;
            ph_r   <= EV_IDLE;
            done_o <= 1'b0;
            cost_o <= '0;
        end else begin
            done_o <= 1'b0;
            case (ph_r)
                EV_IDLE: begin
                    if (go_i) begin
                        for (int i = 0; i < NUM_SENS; i++)
                            xs_r[i] <= word_t'(sens_i[i*DATA_W +: DATA_W]);
                        ph_r <= EV_CONST;
                    end
                end
                EV_CONST: begin
                    acc_r <= coef_rdata_i;
                    idx_r <= '0;
                    ph_r  <= EV_SQ;
                end
                EV_SQ: begin
                    sq_r <= prod;
                    ph_r <= EV_LIN;
                end
                EV_LIN: begin
                    acc_r <= acc_sum;
                    ph_r  <= EV_QD;
                end
                EV_QD: begin
                    acc_r <= acc_sum;
                    if (idx_r == LAST) begin
                        cost_o <= acc_sum;
                        done_o <= 1'b1;
                        ph_r   <= EV_IDLE;
                    end else begin
                        idx_r <= idx_r + IW'(1);
                        ph_r  <= EV_SQ;
                    end
                end
                default: ph_r <= EV_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/knob_sweep_ctrl.sv
// Sweep sequencer. Starting from code 0, it requests a sensor sample,
// launches an evaluation and compares the result with the previous estimate.
// It stops at the first strict rise, stepping back one code, or it stops at
// the maximum code. Assumes eval_done_i arrives only after eval_go_o.
module knob_sweep_ctrl
    import knob_sweep_pkg::*;
#(
    parameter int KNOB_W = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              sens_valid_i,
    input  logic              eval_done_i,
    input  word_t             eval_cost_i,
    output logic              meas_req_o,
    output logic              eval_go_o,
    output logic [KNOB_W-1:0] knob_o,
    output logic              busy_o,
    output logic              done_o,
    output word_t             cost_o
);

    localparam logic [KNOB_W-1:0] KMAX = {KNOB_W{1'b1}};

    sweep_st_t st_r;
    word_t     prev_r;
    logic      first_r;

    // Handshake and status decode from the state.
    assign meas_req_o = (st_r == SW_REQ);
    assign eval_go_o  = meas_req_o && sens_valid_i;
    assign busy_o     = (st_r != SW_IDLE);

    // Sweep state machine: start, sample, evaluate, decide.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_r    <= SW_IDLE;
            knob_o  <= '0;
            prev_r  <= '0;
            first_r <= 1'b1;
            done_o  <= 1'b0;
            cost_o  <= '0;
        end else begin
            case (st_r)
                SW_IDLE: begin
                    if (start_i) begin
                        knob_o  <= '0;
                        first_r <= 1'b1;
                        done_o  <= 1'b0;
                        st_r    <= SW_REQ;
                    end
                end
                SW_REQ: begin
                    if (sens_valid_i) st_r <= SW_EVAL;
                end
                SW_EVAL: begin
                    if (eval_done_i) begin
                        if (!first_r && (eval_cost_i > prev_r)) begin
                            knob_o <= knob_o - KNOB_W'(1);
                            cost_o <= prev_r;
                            done_o <= 1'b1;
                            st_r   <= SW_IDLE;
                        end else if (knob_o == KMAX) begin
                            cost_o <= eval_cost_i;
                            done_o <= 1'b1;
                            st_r   <= SW_IDLE;
                        end else begin
                            prev_r  <= eval_cost_i;
                            first_r <= 1'b0;
                            knob_o  <= knob_o + KNOB_W'(1);
                            st_r    <= SW_REQ;
                        end
                    end
                end
                default: st_r <= SW_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/knob_sweep_opt.sv
// Top of the tuning code sweep controller. It ties together the coefficient
// store, the shared-multiplier evaluator and the sweep sequencer.
// Coefficient writes are gated off while a sweep runs.
module knob_sweep_opt
    import knob_sweep_pkg::*;
#(
    parameter int  KNOB_W   = 6,
    parameter int  NUM_SENS = 6,
    localparam int COEF_N   = 2 * NUM_SENS + 1,
    localparam int CAW      = $clog2(COEF_N)
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    output logic                       meas_req_o,
    input  logic                       sens_valid_i,
    input  logic [NUM_SENS*DATA_W-1:0] sens_data_i,
    input  logic                       coef_we_i,
    input  logic [CAW-1:0]             coef_addr_i,
    input  logic [DATA_W-1:0]          coef_wdata_i,
    output logic [KNOB_W-1:0]          knob_o,
    output logic                       busy_o,
    output logic                       done_o,
    output logic [DATA_W-1:0]          cost_o
);

    logic           wr_ok;
    logic [CAW-1:0] rd_addr;
    word_t          rd_data;
    logic           ev_go;
    logic           ev_done;
    word_t          ev_cost;
    word_t          cost_w;

    // Accept coefficient writes only while idle.
    assign wr_ok  = coef_we_i && !busy_o;
    assign cost_o = cost_w;

    knob_coef_store #(.DEPTH(COEF_N), .CAW(CAW)) store_i (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_ok),
        .waddr_i (coef_addr_i),
        .wdata_i (word_t'(coef_wdata_i)),
        .raddr_i (rd_addr),
        .rdata_o (rd_data)
    );

    knob_quad_eval #(.NUM_SENS(NUM_SENS), .CAW(CAW)) eval_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .go_i         (ev_go),
        .sens_i       (sens_data_i),
        .coef_raddr_o (rd_addr),
        .coef_rdata_i (rd_data),
        .done_o       (ev_done),
        .cost_o       (ev_cost)
    );

    knob_sweep_ctrl #(.KNOB_W(KNOB_W)) ctrl_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start_i      (start_i),
        .sens_valid_i (sens_valid_i),
        .eval_done_i  (ev_done),
        .eval_cost_i  (ev_cost),
        .meas_req_o   (meas_req_o),
        .eval_go_o    (ev_go),
        .knob_o       (knob_o),
        .busy_o       (busy_o),
        .done_o       (done_o),
        .cost_o       (cost_w)
    );

endmodule

// File: rtl/knob_sweep_chk.sv
// Protocol and sequencing checks for the sweep controller, observed at its
// ports and attached to it by bind. Assumes synchronous active-low reset.
module knob_sweep_chk #(
    parameter int KNOB_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start_i,
    input logic              meas_req_o,
    input logic              sens_valid_i,
    input logic [KNOB_W-1:0] knob_o,
    input logic              busy_o,
    input logic              done_o,
    input logic [15:0]       cost_o
);

    // R4
    knob_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o |=> (knob_o == $past(knob_o) ||
                    knob_o == $past(knob_o) + KNOB_W'(1) ||
                    knob_o == $past(knob_o) - KNOB_W'(1)));

    // R4
    start_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && start_i) |=> (busy_o && meas_req_o && !done_o && knob_o == '0));

    // R5
    wait_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req_o && !sens_valid_i) |=> (meas_req_o && $stable(knob_o)));

    // R6
    flag_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_o && busy_o));

    // R9
    restart_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (meas_req_o && start_i) |=> busy_o);

    // R11
    done_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && !start_i) |=> (done_o && $stable(knob_o) && $stable(cost_o)));

endmodule

bind knob_sweep_opt knob_sweep_chk #(.KNOB_W(KNOB_W)) chk_i (
    .clk          (clk),
    .rst_n        (rst_n),
    .start_i      (start_i),
    .meas_req_o   (meas_req_o),
    .sens_valid_i (sens_valid_i),
    .knob_o       (knob_o),
    .busy_o       (busy_o),
    .done_o       (done_o),
    .cost_o       (cost_o)
);

// File: tb/knob_sweep_opt_tb_top.sv
// Directed bench for the tuning code sweep controller. A reference model
// built from the requirements predicts the final code, cost and request count.
module knob_sweep_opt_tb_top;

    localparam int KW   = 6;
    localparam int NS   = 6;
    localparam int DW   = 16;
    localparam int KMAX = (1 << KW) - 1;
    localparam int NC   = 2 * NS + 1;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             start_i = 1'b0;
    logic             meas_req_o;
    logic             sens_valid_i = 1'b0;
    logic [NS*DW-1:0] sens_data_i = '0;
    logic             coef_we_i = 1'b0;
    logic [3:0]       coef_addr_i = '0;
    logic [DW-1:0]    coef_wdata_i = '0;
    logic [KW-1:0]    knob_o;
    logic             busy_o;
    logic             done_o;
    logic [DW-1:0]    cost_o;

    int n_chk = 0;
    int n_bad = 0;
    bit ended = 1'b0;
    int cf [NC];
    int base_v [NS];
    int slope_v [NS];

    knob_sweep_opt #(.KNOB_W(KW), .NUM_SENS(NS)) dut_i (
        .clk (clk), .rst_n (rst_n), .start_i (start_i), .meas_req_o (meas_req_o),
        .sens_valid_i (sens_valid_i), .sens_data_i (sens_data_i),
        .coef_we_i (coef_we_i), .coef_addr_i (coef_addr_i), .coef_wdata_i (coef_wdata_i),
        .knob_o (knob_o), .busy_o (busy_o), .done_o (done_o), .cost_o (cost_o)
    );

    always #5 clk = ~clk;

    function automatic int satb(longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return int'(v);
    endfunction

    function automatic int mulb(int a, int b);
        longint p;
        p = longint'(a) * longint'(b);
        p = p >>> 8;
        return satb(p);
    endfunction

    function automatic int sv(int i, int k);
        return satb(longint'(base_v[i]) + longint'(slope_v[i]) * k);
    endfunction

    function automatic int cost_of(int k);
        int acc;
        acc = cf[0];
        for (int i = 0; i < NS; i++) begin
            acc = satb(longint'(acc) + mulb(cf[1+i], sv(i, k)));
            acc = satb(longint'(acc) + mulb(cf[1+NS+i], mulb(sv(i, k), sv(i, k))));
        end
        return acc;
    endfunction

    function automatic logic [NS*DW-1:0] vec(int k);
        logic [NS*DW-1:0] v;
        for (int i = 0; i < NS; i++) v[i*DW +: DW] = DW'(sv(i, k));
        return v;
    endfunction

    task automatic check(string what, longint act, longint exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s act=%0d exp=%0d", what, act, exp);
        end
    endtask

    task automatic summary();
        if (!ended) begin
            ended = 1'b1;
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr_coef(int a, int v);
        @(negedge clk);
        coef_we_i = 1'b1; coef_addr_i = 4'(a); coef_wdata_i = DW'(v);
        @(negedge clk);
        coef_we_i = 1'b0;
        cf[a] = satb(v);
    endtask

    task automatic prep();
        for (int a = 0; a < NC; a++) wr_coef(a, 0);
        for (int i = 0; i < NS; i++) begin base_v[i] = 0; slope_v[i] = 0; end
    endtask

    task automatic walk(output int ek, output int ec, output int er);
        int prev;
        prev = 0;
        ek = 0; ec = 0; er = 0;
        for (int k = 0; k <= KMAX; k++) begin
            int c;
            c = cost_of(k);
            if (k > 0 && c > prev) begin ek = k - 1; ec = prev; er = k + 1; return; end
            if (k == KMAX) begin ek = k; ec = c; er = k + 1; return; end
            prev = c;
        end
    endtask

    task automatic pulse_start();
        @(negedge clk); start_i = 1'b1;
        @(negedge clk); start_i = 1'b0;
    endtask

    // Answer measurement requests until the sweep finishes.
    task automatic serve(int delay, int start_at, int write_at, output int nreq);
        nreq = 0;
        while (1) begin
            @(negedge clk);
            if (done_o && !busy_o) break;
            if (meas_req_o) begin
                int k;
                k = int'(knob_o);
                if (nreq == start_at) begin
                    start_i = 1'b1; @(negedge clk); start_i = 1'b0;
                end
                if (nreq == write_at) begin
                    coef_we_i = 1'b1; coef_addr_i = 4'd0; coef_wdata_i = 16'd5000;
                    @(negedge clk); coef_we_i = 1'b0;
                end
                repeat (delay) @(negedge clk);
                if (delay > 0) begin
                    check("R5 code held while waiting", knob_o, k);
                    check("R5 request held while waiting", meas_req_o, 1);
                end
                sens_data_i = vec(k);
                sens_valid_i = 1'b1;
                @(negedge clk);
                sens_valid_i = 1'b0;
                nreq++;
            end
        end
    endtask

    task automatic finish_chk(string tag, int ek, int ec, int er, int nreq);
        check({tag, " final code"}, knob_o, ek);
        check({tag, " final cost"}, longint'($signed(cost_o)), ec);
        check({tag, " done"}, done_o, 1);
        check({tag, " busy"}, busy_o, 0);
        check({tag, " requests"}, nreq, er);
    endtask

    task automatic sweep(string tag, int delay, int start_at, int write_at);
        int ek, ec, er, nreq;
        walk(ek, ec, er);
        pulse_start();
        check({tag, " R4 busy after start"}, busy_o, 1);
        check({tag, " R4 code zero after start"}, knob_o, 0);
        serve(delay, start_at, write_at, nreq);
        finish_chk(tag, ek, ec, er, nreq);
    endtask

    task automatic set_bowl();
        prep();
        wr_coef(0, 100);
        wr_coef(7, 256);
        base_v[0] = -320; slope_v[0] = 32;
    endtask

    task automatic t_reset();
        do_reset();
        check("R1 knob", knob_o, 0);
        check("R1 busy", busy_o, 0);
        check("R1 done", done_o, 0);
        check("R1 cost", cost_o, 0);
        check("R1 request", meas_req_o, 0);
    endtask

    task automatic t_bowl();
        set_bowl();
        sweep("R6 bowl", 0, -1, -1);
        check("R6 explicit code", knob_o, 10);
        check("R6 explicit cost", longint'($signed(cost_o)), 100);
    endtask

    task automatic t_hold();
        repeat (20) @(negedge clk);
        check("R11 code held", knob_o, 10);
        check("R11 cost held", longint'($signed(cost_o)), 100);
        check("R11 done held", done_o, 1);
    endtask

    task automatic t_max();
        prep();
        wr_coef(0, 100); wr_coef(1, -256);
        slope_v[0] = 16;
        sweep("R8 falling", 0, -1, -1);
        check("R8 max code", knob_o, KMAX);
    endtask

    task automatic t_first_up();
        prep();
        wr_coef(0, 40); wr_coef(1, 256);
        slope_v[0] = 16;
        sweep("R6 first rise", 0, -1, -1);
    endtask

    task automatic t_flat();
        prep();
        wr_coef(0, -50);
        sweep("R7 flat", 0, -1, -1);
    endtask

    task automatic t_sat();
        prep();
        wr_coef(0, 30000); wr_coef(7, 32767); wr_coef(2, -32768);
        base_v[0] = 32767; base_v[1] = 32767;
        sweep("R3 saturation", 0, -1, -1);
        check("R3 saturated cost", longint'($signed(cost_o)), -1);
    endtask

    task automatic t_multi();
        int lin [NS] = '{64, -32, 128, 16, -8, 200};
        int qd  [NS] = '{128, 64, -20, 32, 100, 10};
        int bs  [NS] = '{-200, 300, 50, -1000, 700, 20};
        int sl  [NS] = '{25, -10, 3, 40, -30, 1};
        prep();
        wr_coef(0, -500);
        for (int i = 0; i < NS; i++) begin
            wr_coef(1 + i, lin[i]);
            wr_coef(1 + NS + i, qd[i]);
            base_v[i] = bs[i]; slope_v[i] = sl[i];
        end
        sweep("R2 R3 six sensors", 0, -1, -1);
    endtask

    task automatic t_gate();
        set_bowl();
        sweep("R5 slow valid", 5, -1, -1);
    endtask

    task automatic t_busy_start();
        set_bowl();
        sweep("R9 start while busy", 0, 3, -1);
    endtask

    task automatic t_busy_write();
        set_bowl();
        sweep("R10 write while busy", 0, -1, 2);
    endtask

    task automatic t_same_cycle();
        int ek, ec, er, nreq;
        set_bowl();
        @(negedge clk);
        start_i = 1'b1; coef_we_i = 1'b1; coef_addr_i = 4'd0; coef_wdata_i = 16'd777;
        @(negedge clk);
        start_i = 1'b0; coef_we_i = 1'b0;
        cf[0] = 777;
        walk(ek, ec, er);
        serve(0, -1, -1, nreq);
        finish_chk("R10 write with start", ek, ec, er, nreq);
        check("R10 new constant used", longint'($signed(cost_o)), 777);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!ended) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired act=running exp=finished");
            summary();
        end
    end

    initial begin
        t_reset();
        t_bowl();
        t_hold();
        t_max();
        t_first_up();
        t_flat();
        t_sat();
        t_multi();
        t_gate();
        t_busy_start();
        t_busy_write();
        t_same_cycle();
        summary();
    end

endmodule